// File: doc/BRIEF.md
# I2C Target Register Memory

This block is an I2C bus target that holds a 128-byte register file. It watches the SCL and SDA lines from a system clock that runs far faster than SCL, answers to one fixed 7-bit device address, and pulls SDA low only to acknowledge or to send a zero. A controller first writes a byte address and then either writes data bytes or, after a repeated START with the read bit set, reads them back.

The byte-address byte has two parts. The top bit picks the pointer mode: 1 means burst and 0 means single. The lower seven bits pick the memory byte. In burst mode the pointer steps forward after every data byte and wraps from 127 to 0. In single mode it stays on one location. The pointer survives a repeated START, so a read can be preceded by a dummy write that only sets the address. A local port sits beside the bus. It can write any byte on a system clock edge and read any byte combinationally, which lets the memory be preloaded and inspected.

Top module: `i2c_reg_target`

## Requirements
- R1: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START at any point restarts device-address reception with an empty bit count. A STOP returns the target to idle with SDA released.
- R2: After START the target shifts in 8 bits, MSB first, each sampled on an SCL rising edge. The first 7 bits are the device address and the 8th is the direction (0 write, 1 read). On a match with DEV_ADDR the target acknowledges by holding SDA low through the 9th clock.
- R3: When the device address does not match, the target does not acknowledge. It drives nothing and writes nothing until the next START or STOP.
- R4: In a write-direction transfer the byte after the device address is the byte address: bit 7 is the mode flag (1 burst, 0 single) and bits 6:0 are the memory index. The target acknowledges it.
- R5: Each further byte of a write transfer is stored at the current pointer and acknowledged.
- R6: In single mode the pointer does not move. Successive writes replace the same byte and successive reads return the same byte.
- R7: In burst mode the pointer increments after each data byte, written or read, and wraps from 127 to 0.
- R8: A read-direction device address acknowledged after a repeated START makes the target send memory bytes MSB first, starting at the pointer left by the earlier address phase.
- R9: When the controller answers a read byte with a NACK (SDA high on the 9th clock), the target releases SDA and sends nothing more until the next START.
- R10: SDA is open drain: the target only asserts a pull-low enable. It asserts the enable only after a falling SCL edge, never while SCL is high, and it never drives while idle.
- R11: A local write stores a byte on the next system clock edge. A local read returns the addressed byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as resolved on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1; release when 0 |
| loc_we_i | input | 1 | Local write strobe |
| loc_addr_i | input | 7 | Local byte index |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data, combinational |

## Verification
Each bus line passes through two synchronizer flops, and one more register detects the edge, so the pull-low enable changes three system clocks after SCL falls. The bench holds SCL low for eight clocks and reads the wire in the middle of the high phase, well after that latency has passed. A local read is checked one clock after the address is applied. A bus write is checked through the local port only after the STOP, which is many clocks after the store. A per-clock monitor compares the enable with its value on the previous clock and flags any change while the bench holds SCL high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_RD
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o   = scl_pipe[STAGES-1];
  assign sda_o   = sda_pipe[STAGES-1];
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
  // line changes while the clock stays high
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_mem.sv
module i2c_tgt_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          loc_we_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic [DW-1:0] loc_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // local port written last: wins on a same-cycle collision
  always_ff @(posedge clk_i) begin
    if (bus_we_i) mem_q[bus_addr_i] <= bus_wdata_i;
    if (loc_we_i) mem_q[loc_addr_i] <= loc_wdata_i;
  end

  assign bus_rdata_o = mem_q[bus_addr_i];
  assign loc_rdata_o = mem_q[loc_addr_i];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 7,
  parameter int         DW       = 8,
  localparam int        CNT_W    = $clog2(DW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             mem_we_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [AW-1:0]    ptr_o,
  output logic             burst_o,
  output logic             sda_low_o,
  output tgt_state_e       state_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);

  tgt_state_e       state;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    shreg;
  logic [AW-1:0]    ptr;
  logic             burst, rw, in_ack, nack, sda_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      burst   <= 1'b0;
      rw      <= 1'b0;
      in_ack  <= 1'b0;
      nack    <= 1'b0;
      sda_low <= 1'b0;
    end else if (start_i) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_low <= 1'b0;
    end else if (stop_i) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_low <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (rise_i) begin
        if (in_ack) begin
          nack <= sda_i;
        end else if (bit_cnt != LAST) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (state != ST_RD) shreg <= {shreg[DW-2:0], sda_i};
        end
      end else if (fall_i) begin
        if (in_ack) begin
          // end of the ninth clock
          in_ack  <= 1'b0;
          bit_cnt <= '0;
          sda_low <= 1'b0;
          case (state)
            ST_DEV: begin
              if (rw) begin
                state   <= ST_RD;
                shreg   <= rd_data_i;
                sda_low <= ~rd_data_i[DW-1];
              end else begin
                state <= ST_ADDR;
              end
            end
            ST_ADDR: state <= ST_WR;
            ST_RD: begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                shreg   <= rd_data_i;
                sda_low <= ~rd_data_i[DW-1];
              end
            end
            default: ;
          endcase
        end else if (bit_cnt == LAST) begin
          // start of the ninth clock
          case (state)
            ST_DEV: begin
              if (shreg[DW-1:1] == DEV_ADDR) begin
                in_ack  <= 1'b1;
                sda_low <= 1'b1;
                rw      <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              in_ack  <= 1'b1;
              sda_low <= 1'b1;
              ptr     <= shreg[AW-1:0];
              burst   <= shreg[DW-1];
            end
            ST_WR: begin
              in_ack  <= 1'b1;
              sda_low <= 1'b1;
              if (burst) ptr <= ptr + AW'(1);
            end
            ST_RD: begin
              in_ack  <= 1'b1;
              sda_low <= 1'b0;
              if (burst) ptr <= ptr + AW'(1);
            end
            default: ;
          endcase
        end else if (state == ST_RD && bit_cnt != '0) begin
          sda_low <= ~shreg[DW-2];
          shreg   <= {shreg[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign mem_we_o    = fall_i && !start_i && !stop_i && state == ST_WR &&
                       bit_cnt == LAST && !in_ack;
  assign mem_wdata_o = shreg;
  assign ptr_o       = ptr;
  assign burst_o     = burst;
  assign sda_low_o   = sda_low;
  assign state_o     = state;
  assign bit_cnt_o   = bit_cnt;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 7,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        CNT_W       = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          loc_we_i,
  input  logic [AW-1:0] loc_addr_i,
  input  logic [DW-1:0] loc_wdata_i,
  output logic [DW-1:0] loc_rdata_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             mem_we, burst;
  logic [DW-1:0]    mem_wdata, rd_data;
  logic [AW-1:0]    ptr;
  logic [CNT_W-1:0] bit_cnt;
  tgt_state_e       state;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .rise_i      (scl_rise),
    .fall_i      (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .rd_data_i   (rd_data),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .ptr_o       (ptr),
    .burst_o     (burst),
    .sda_low_o   (sda_oe_o),
    .state_o     (state),
    .bit_cnt_o   (bit_cnt)
  );

  i2c_tgt_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i       (clk_i),
    .bus_we_i    (mem_we),
    .bus_addr_i  (ptr),
    .bus_wdata_i (mem_wdata),
    .bus_rdata_o (rd_data),
    .loc_we_i    (loc_we_i),
    .loc_addr_i  (loc_addr_i),
    .loc_wdata_i (loc_wdata_i),
    .loc_rdata_o (loc_rdata_o)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int AW    = 7,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input tgt_state_e       state,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [AW-1:0]    ptr,
  input logic             burst,
  input logic             sda_oe_o
);
  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state == ST_DEV && bit_cnt == '0)); // R1

  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state == ST_IDLE && !sda_oe_o)); // R1

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o); // R3

  AST_PULL_ON_LOW_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s)); // R10

  AST_SINGLE_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst && !$stable(ptr)) |-> ($past(state) == ST_ADDR)); // R6
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state),
  .bit_cnt   (bit_cnt),
  .ptr       (ptr),
  .burst     (burst),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl = 1'b1;
  logic sda_ctl = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_ctl & ~sda_oe;

  logic       loc_we = 1'b0;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic [7:0] loc_rdata;

  i2c_reg_target #(.DEV_ADDR(DEV)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .loc_we_i    (loc_we),
    .loc_addr_i  (loc_addr),
    .loc_wdata_i (loc_wdata),
    .loc_rdata_o (loc_rdata)
  );

  int errors = 0;
  int checks = 0;
  int viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  logic [7:0] ref_mem [128];
  int ref_ptr = 0;
  bit ref_burst = 1'b0;
  logic [7:0] wq[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock compare: the pull-low enable must hold while SCL is high (R10)
  always @(posedge clk) begin
    if (rst_n) begin
      if (scl && sda_oe !== oe_prev) viol++;
      oe_prev = sda_oe;
    end
  end

  task automatic bus_bit(input logic b, output logic seen);
    sda_ctl = b;
    wait_clk(4);
    scl = 1'b1;
    wait_clk(4);
    seen = sda_line;
    wait_clk(4);
    scl = 1'b0;
    wait_clk(4);
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1;
    wait_clk(4);
    scl = 1'b1;
    wait_clk(4);
    sda_ctl = 1'b0;
    wait_clk(4);
    scl = 1'b0;
    wait_clk(4);
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0;
    wait_clk(4);
    scl = 1'b1;
    wait_clk(4);
    sda_ctl = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      v[i] = s;
    end
    bus_bit(nack, s);
  endtask

  task automatic loc_write(input logic [6:0] a, input logic [7:0] d);
    loc_addr = a;
    loc_wdata = d;
    loc_we = 1'b1;
    wait_clk(1);
    loc_we = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic loc_check(input string tag, input logic [6:0] a);
    loc_addr = a;
    wait_clk(1);
    chk(tag, int'(loc_rdata), int'(ref_mem[a]));
  endtask

  // write transfer; data taken from wq
  task automatic do_write(input string tag, input logic [7:0] abyte);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk({tag, " R2 dev ack"}, int'(ack), 1);
    send_byte(abyte, ack);
    chk({tag, " R4 addr ack"}, int'(ack), 1);
    ref_ptr = int'(abyte[6:0]);
    ref_burst = abyte[7];
    foreach (wq[k]) begin
      send_byte(wq[k], ack);
      chk({tag, " R5 data ack"}, int'(ack), 1);
      ref_mem[ref_ptr] = wq[k];
      if (ref_burst) ref_ptr = (ref_ptr + 1) % 128;
    end
    bus_stop();
    wq.delete();
  endtask

  // dummy write of the address, repeated START, then n reads
  task automatic do_read(input string tag, input logic [7:0] abyte, input int n);
    logic ack;
    logic s;
    logic [7:0] v;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk({tag, " R2 dev ack"}, int'(ack), 1);
    send_byte(abyte, ack);
    chk({tag, " R4 addr ack"}, int'(ack), 1);
    ref_ptr = int'(abyte[6:0]);
    ref_burst = abyte[7];
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk({tag, " R8 read dev ack"}, int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, v);
      chk({tag, " R8 read data"}, int'(v), int'(ref_mem[ref_ptr]));
      if (ref_burst) ref_ptr = (ref_ptr + 1) % 128;
    end
    // after NACK the line must stay released
    bus_bit(1'b1, s);
    chk({tag, " R9 released after nack"}, int'(s), 1);
    bus_stop();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic s;
    wait_clk(3);
    chk("R10 reset released", int'(sda_oe), 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R11 preload and local readback
    for (int i = 0; i < 128; i++) loc_write(7'(i), 8'(i) ^ 8'h5A);
    loc_check("R11 local read 0", 7'h00);
    loc_check("R11 local read 127", 7'h7F);
    loc_write(7'h40, 8'h9C);
    loc_check("R11 local write", 7'h40);

    // R5 R7 burst write
    wq = '{8'hA1, 8'hB2, 8'hC3};
    do_write("burst wr", 8'h90);
    loc_check("R5 burst byte0", 7'h10);
    loc_check("R7 burst byte1", 7'h11);
    loc_check("R7 burst byte2", 7'h12);

    // R6 single write: same location overwritten, neighbour untouched
    wq = '{8'h11, 8'h22};
    do_write("single wr", 8'h20);
    loc_check("R6 single target", 7'h20);
    loc_check("R6 single neighbour", 7'h21);

    // R7 wrap on write
    wq = '{8'h01, 8'h02};
    do_write("wrap wr", 8'hFF);
    loc_check("R7 wrap wr 127", 7'h7F);
    loc_check("R7 wrap wr 0", 7'h00);

    // R7 R8 R9 burst read across the wrap
    do_read("burst rd", 8'hFE, 3);

    // R6 single read returns the same byte
    do_read("single rd", 8'h20, 2);

    // R3 wrong device address
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk("R3 no dev ack", int'(ack), 0);
    send_byte(8'h85, ack);
    chk("R3 no addr ack", int'(ack), 0);
    send_byte(8'hEE, ack);
    chk("R3 no data ack", int'(ack), 0);
    bus_stop();
    loc_check("R3 mem untouched", 7'h05);

    // R1 START in the middle of a byte restarts reception
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk("R1 dev ack", int'(ack), 1);
    bus_bit(1'b1, s);
    bus_bit(1'b0, s);
    bus_bit(1'b1, s);
    bus_bit(1'b0, s);
    wq = '{8'h77};
    do_write("R1 restart", 8'h30);
    loc_check("R1 restart write", 7'h30);
    chk("R1 released after stop", int'(sda_oe), 0);

    chk("R10 no change while SCL high", viol, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule